// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital half of a successive-approximation analog-to-digital converter in a small 8-bit microcontroller. Software talks to it over a byte-wide register bus with three addresses: a control and status register, a result-high register, and a combined result-low and configuration register. The block chooses one of eight analog inputs. It derives a conversion tick from the system clock, either divided by 16 or undivided. On each tick it resolves one bit of the result, starting at the most significant bit, against a one-bit comparator input.

During a conversion the block drives a 12-bit trial code to the external DAC. When the conversion completes, it stores the result, raises an end-of-conversion flag and clears the start bit in the same clock edge. Resolution is chosen at run time. An 8-bit result occupies only the high register. A 12-bit result spans the high register and the low nibble of the configuration register.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, address 0xB1 reads 0x00, 0xB2 reads 0x00 and 0xB3 reads 0x00. `dac_code` is 0 and `mux_en` is 0.
- R2: Register 0xB1 holds enable (bit 7), start (bit 6), end-of-conversion flag (bit 5), channel enable (bit 4) and channel number (bits 2:0). Bit 3 always reads 0. Software writes to bit 5 have no effect.
- R3: Register 0xB3 holds the clock select (bit 6, 1 = every system clock, 0 = every 16th) and the resolution select (bit 5, 1 = 12-bit, 0 = 8-bit). Bits 7 and 4 always read 0.
- R4: Writes to 0xB2, and to bits 3:0 of 0xB3, leave the stored result unchanged.
- R5: A write to 0xB1 with bits 7 and 6 both 1, made while no conversion runs, starts a conversion and clears the flag. A write with bit 7 at 0 leaves start at 0 and starts nothing.
- R6: The conversion tries bits from bit 11 downward. Each trial sets the current bit on top of the bits already kept. The trial bit is kept when `cmp_in` is 1. Between ticks `dac_code` is stable. The first trial code is 0x800.
- R7: In 8-bit mode only bits 11:4 are tried, taking 8 ticks. 0xB2 receives the result bits 11:4 and the low nibble of 0xB3 is written 0. The resolution is taken when the conversion starts.
- R8: In 12-bit mode 12 ticks resolve the full code. Bits 11:4 go to 0xB2 and bits 3:0 go to 0xB3[3:0].
- R9: The flag rises N×16 clock edges after the starting write's edge with the divided clock, and N edges after it with the undivided clock. N is the resolution.
- R10: On completion the flag becomes 1, start becomes 0 and the result registers update, all on the same edge. Start and the flag are never both 1.
- R11: `mux_sel` equals the channel number. `mux_en` is 1 only when both the enable bit and the channel enable bit are 1.
- R12: Writing 0xB1 with bit 7 at 0 during a conversion aborts it. Start goes to 0, the flag stays 0 and the result registers keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| cmp_in | input | 1 | Comparator: 1 when input is at or above the DAC level |
| dac_code | output | 12 | Trial code to the DAC |
| mux_sel | output | 3 | Analog input select |
| mux_en | output | 1 | Analog multiplexer enable |

## Verification
Several rules are checked on every cycle. Start and the flag are never both set, and the flag rises exactly as start falls. The multiplexer is gated by the two enable bits. The trial code holds still between ticks, and its low nibble stays clear during an 8-bit conversion. An abort leaves the sequencer idle, and the reserved bits of the configuration register read 0. Other properties can only be shown by the bench's scenarios. These are the arithmetic value of each result against a modelled input voltage across all channels and both resolutions, the exact tick latency at both clock rates, and the immunity of the result to bus writes. The bench also shows that a write without enable starts nothing and that an abort keeps the previous result.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  localparam logic [7:0] ADDR_CTRL = 8'hB1;
  localparam logic [7:0] ADDR_RHI  = 8'hB2;
  localparam logic [7:0] ADDR_RLO  = 8'hB3;

  localparam int CTRL_EN_BIT   = 7;
  localparam int CTRL_GO_BIT   = 6;
  localparam int CTRL_DONE_BIT = 5;
  localparam int CTRL_GCH_BIT  = 4;
  localparam int CFG_FAST_BIT  = 6;
  localparam int CFG_RES_BIT   = 5;

  localparam int CODE_W = 12;
  localparam int HI_W   = 8;
  localparam int LO_W   = CODE_W - HI_W;
endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run & (fast | wrap);
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int W     = 12,
  parameter int LOW_W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_go,
  input  logic         abort,
  input  logic         res_full,
  input  logic         tick,
  input  logic         cmp,
  output logic         busy,
  output logic         res_lat,
  output logic         done,
  output logic [W-1:0] dac_code,
  output logic [W-1:0] conv_res
);
  localparam int IW = $clog2(W);
  localparam logic [IW-1:0] TOP_IDX  = IW'(W - 1);
  localparam logic [IW-1:0] SHORT_LSB = IW'(W - LOW_W);

  logic          busy_q, busy_d;
  logic          res_q, res_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [W-1:0]  acc_q, acc_d;
  logic [W-1:0]  onehot, trial, kept;
  logic [IW-1:0] lsb_idx;
  logic          last;

  assign onehot  = {{(W-1){1'b0}}, 1'b1} << idx_q;
  assign trial   = acc_q | onehot;
  assign kept    = cmp ? trial : acc_q;
  assign lsb_idx = res_q ? '0 : SHORT_LSB;
  assign last    = (idx_q == lsb_idx);

  always_comb begin
    busy_d = busy_q;
    res_d  = res_q;
    idx_d  = idx_q;
    acc_d  = acc_q;
    if (start_go) begin
      busy_d = 1'b1;
      res_d  = res_full;
      idx_d  = TOP_IDX;
      acc_d  = '0;
    end else if (abort) begin
      busy_d = 1'b0;
    end else if (busy_q && tick) begin
      acc_d = kept;
      if (last) busy_d = 1'b0;
      else      idx_d  = idx_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      res_q  <= 1'b0;
      idx_q  <= '0;
      acc_q  <= '0;
    end else begin
      busy_q <= busy_d;
      res_q  <= res_d;
      idx_q  <= idx_d;
      acc_q  <= acc_d;
    end
  end

  assign busy     = busy_q;
  assign res_lat  = res_q;
  assign done     = busy_q & tick & last & ~abort;
  assign conv_res = kept;
  assign dac_code = busy_q ? trial : acc_q;
endmodule

// File: rtl/sar_regs.sv
module sar_regs
  import sar_adc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [7:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [CODE_W-1:0] conv_res,
  output logic              en,
  output logic              start,
  output logic              eoc,
  output logic              gch,
  output logic [2:0]        ch,
  output logic              fast,
  output logic              res_full,
  output logic              start_go,
  output logic              abort
);
  logic            en_q, en_d, go_q, go_d, eoc_q, eoc_d, gch_q, gch_d;
  logic [2:0]      ch_q, ch_d;
  logic            fast_q, fast_d, res_q, res_d;
  logic [HI_W-1:0] hi_q, hi_d;
  logic [LO_W-1:0] lo_q, lo_d;
  logic            ctrl_wr, cfg_wr;
  logic            unused_wbit;

  assign unused_wbit = bus_wdata[3];
  assign ctrl_wr  = bus_we && (bus_addr == ADDR_CTRL);
  assign cfg_wr   = bus_we && (bus_addr == ADDR_RLO);
  assign start_go = ctrl_wr && bus_wdata[CTRL_EN_BIT] && bus_wdata[CTRL_GO_BIT] && !busy;
  assign abort    = ctrl_wr && !bus_wdata[CTRL_EN_BIT] && busy;

  always_comb begin
    en_d   = en_q;
    go_d   = go_q;
    eoc_d  = eoc_q;
    gch_d  = gch_q;
    ch_d   = ch_q;
    fast_d = fast_q;
    res_d  = res_q;
    hi_d   = hi_q;
    lo_d   = lo_q;
    if (ctrl_wr) begin
      en_d  = bus_wdata[CTRL_EN_BIT];
      gch_d = bus_wdata[CTRL_GCH_BIT];
      ch_d  = bus_wdata[2:0];
      if (!bus_wdata[CTRL_EN_BIT]) go_d = 1'b0;
    end
    if (start_go) begin
      go_d  = 1'b1;
      eoc_d = 1'b0;
    end
    if (done) begin
      go_d  = 1'b0;
      eoc_d = 1'b1;
      hi_d  = conv_res[CODE_W-1:LO_W];
      lo_d  = conv_res[LO_W-1:0];
    end
    if (cfg_wr) begin
      fast_d = bus_wdata[CFG_FAST_BIT];
      res_d  = bus_wdata[CFG_RES_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      go_q   <= 1'b0;
      eoc_q  <= 1'b0;
      gch_q  <= 1'b0;
      ch_q   <= '0;
      fast_q <= 1'b0;
      res_q  <= 1'b0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      en_q   <= en_d;
      go_q   <= go_d;
      eoc_q  <= eoc_d;
      gch_q  <= gch_d;
      ch_q   <= ch_d;
      fast_q <= fast_d;
      res_q  <= res_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_CTRL: bus_rdata = {en_q, go_q, eoc_q, gch_q, 1'b0, ch_q};
      ADDR_RHI:  bus_rdata = hi_q;
      ADDR_RLO:  bus_rdata = {1'b0, fast_q, res_q, 1'b0, lo_q};
      default:   bus_rdata = 8'h00;
    endcase
  end

  assign en       = en_q;
  assign start    = go_q;
  assign eoc      = eoc_q;
  assign gch      = gch_q;
  assign ch       = ch_q;
  assign fast     = fast_q;
  assign res_full = res_q;
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int CLK_DIV = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [7:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              cmp_in,
  output logic [CODE_W-1:0] dac_code,
  output logic [2:0]        mux_sel,
  output logic              mux_en
);
  logic              en_w, start_w, eoc_w, gch_w, fast_w, res_w;
  logic [2:0]        ch_w;
  logic              start_go_w, abort_w, busy_w, res_lat_w, done_w, tick_w;
  logic [CODE_W-1:0] conv_res_w;

  sar_regs regs_i (
    .clk(clk), .rst_n(rst_n),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy_w), .done(done_w), .conv_res(conv_res_w),
    .en(en_w), .start(start_w), .eoc(eoc_w), .gch(gch_w), .ch(ch_w),
    .fast(fast_w), .res_full(res_w), .start_go(start_go_w), .abort(abort_w)
  );

  sar_tick_gen #(.DIV(CLK_DIV)) tick_i (
    .clk(clk), .rst_n(rst_n), .run(busy_w), .fast(fast_w), .tick(tick_w)
  );

  sar_seq #(.W(CODE_W), .LOW_W(HI_W)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .start_go(start_go_w), .abort(abort_w), .res_full(res_w),
    .tick(tick_w), .cmp(cmp_in),
    .busy(busy_w), .res_lat(res_lat_w), .done(done_w),
    .dac_code(dac_code), .conv_res(conv_res_w)
  );

  assign mux_sel = ch_w;
  assign mux_en  = en_w & gch_w;
endmodule

// File: rtl/sar_adc_chk.sv
module sar_adc_chk
  import sar_adc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              start,
  input logic              eoc,
  input logic              gch,
  input logic              mux_en,
  input logic              busy,
  input logic              res_lat,
  input logic              tick,
  input logic [CODE_W-1:0] dac_code,
  input logic [7:0]        bus_addr,
  input logic [7:0]        bus_rdata
);
  // R10
  start_eoc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && eoc));

  // R10
  eoc_with_start_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc) |-> $fell(start));

  // R11
  mux_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && gch) |-> !mux_en);

  // R5
  start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> en);

  // R6
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(tick)) |-> $stable(dac_code));

  // R7
  short_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !res_lat) |-> (dac_code[LO_W-1:0] == '0));

  // R12
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> !busy);

  // R3
  cfg_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_RLO) |-> (!bus_rdata[7] && !bus_rdata[4]));
endmodule

bind sar_adc_ctrl sar_adc_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en(en_w), .start(start_w), .eoc(eoc_w),
  .gch(gch_w), .mux_en(mux_en), .busy(busy_w), .res_lat(res_lat_w),
  .tick(tick_w), .dac_code(dac_code), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/sar_adc_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_adc_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        cmp_in;
  logic [11:0] dac_code;
  logic [2:0]  mux_sel;
  logic        mux_en;
  logic [11:0] vin [8];
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  sar_adc_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_in(cmp_in),
    .dac_code(dac_code), .mux_sel(mux_sel), .mux_en(mux_en)
  );

  always_comb cmp_in = mux_en ? (vin[mux_sel] >= dac_code) : 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // starts a conversion and returns edges until the flag is seen
  task automatic convert(input logic [2:0] c, input bit full, input bit fst,
                         input bit gen, output int edges);
    logic [7:0] r;
    wr(8'hB3, {1'b0, fst, full, 5'b0});
    wr(8'hB1, {1'b1, 1'b1, 1'b0, gen, 1'b0, c});
    edges = 0;
    bus_addr = 8'hB1;
    do begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      rd(8'hB1, r);
    end while (!r[5] && edges < 400);
  endtask

  task automatic conv_check(input logic [2:0] c, input bit full, input bit fst);
    int n, exp_n;
    logic [7:0] r, hi, lo;
    logic [11:0] v;
    v = vin[c];
    convert(c, full, fst, 1'b1, n);
    exp_n = (full ? 12 : 8) * (fst ? 1 : 16);
    check(n == exp_n, "R9 latency", n, exp_n);
    rd(8'hB1, r);
    check(r[6] == 1'b0 && r[5] == 1'b1, "R10 flag/start", r, 8'hA0);
    check(mux_sel == c, "R11 mux_sel", mux_sel, c);
    rd(8'hB2, hi);
    rd(8'hB3, lo);
    if (full) begin
      check(hi == v[11:4], "R8 high", hi, v[11:4]);
      check(lo[3:0] == v[3:0], "R8 low", lo[3:0], v[3:0]);
    end else begin
      check(hi == v[11:4], "R7 high", hi, v[11:4]);
      check(lo[3:0] == 4'h0, "R7 low zero", lo[3:0], 0);
    end
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r, hi0, lo0;
    int n;
    vin[0] = 12'h000; vin[1] = 12'hFFF; vin[2] = 12'h800; vin[3] = 12'h7FF;
    vin[4] = 12'h001; vin[5] = 12'h00F; vin[6] = 12'h010; vin[7] = 12'hA5C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'hB1, r); check(r == 8'h00, "R1 ctrl", r, 0);
    rd(8'hB2, r); check(r == 8'h00, "R1 rhi", r, 0);
    rd(8'hB3, r); check(r == 8'h00, "R1 rlo", r, 0);
    check(dac_code == 12'h000, "R1 dac", dac_code, 0);
    check(mux_en == 1'b0, "R1 mux_en", mux_en, 0);

    // R2 layout: bit3 reads 0, flag not writable; R11 gating
    wr(8'hB1, 8'hBF & ~8'h40);
    rd(8'hB1, r); check(r == 8'h97, "R2 ctrl readback", r, 8'h97);
    check(mux_en == 1'b1 && mux_sel == 3'd7, "R11 enabled mux", {mux_en, mux_sel}, 4'hF);
    wr(8'hB1, 8'h07);
    check(mux_en == 1'b0, "R11 en low gates mux", mux_en, 0);
    wr(8'hB1, 8'h80);
    check(mux_en == 1'b0, "R11 gch low gates mux", mux_en, 0);

    // R3 config bits, reserved bits read 0
    wr(8'hB3, 8'hFF);
    rd(8'hB3, r); check(r == 8'h60, "R3 cfg readback", r, 8'h60);

    // R5 start without enable is ignored
    wr(8'hB1, 8'h51);
    rd(8'hB1, r); check(r[6] == 1'b0, "R5 start ignored", r[6], 0);
    repeat (40) @(negedge clk);
    rd(8'hB1, r); check(r[5] == 1'b0, "R5 no conversion", r[5], 0);
    check(dac_code == 12'h000, "R5 dac idle", dac_code, 0);

    // exhaustive channel x resolution x clock sweep: R7 R8 R9 R10 R11
    for (int f = 0; f < 2; f++)
      for (int res = 0; res < 2; res++)
        for (int c = 0; c < 8; c++)
          conv_check(3'(c), res[0], f[0]);

    // R4 result immune to writes
    rd(8'hB2, hi0); rd(8'hB3, lo0);
    wr(8'hB2, ~hi0);
    wr(8'hB3, {lo0[7:4], ~lo0[3:0]});
    rd(8'hB2, r); check(r == hi0, "R4 rhi write", r, hi0);
    rd(8'hB3, r); check(r == lo0, "R4 rlo write", r, lo0);

    // R2 flag cannot be cleared by write
    wr(8'hB1, 8'h97);
    rd(8'hB1, r); check(r[5] == 1'b1, "R2 flag not writable", r[5], 1);

    // voltage sweep on channel 0, 12-bit fast: R6 R8
    for (int k = 0; k < 4096; k += 37) begin
      vin[0] = 12'(k);
      conv_check(3'd0, 1'b1, 1'b1);
    end

    // R6 first trial and second trial, then R12 abort
    rd(8'hB2, hi0); rd(8'hB3, lo0);
    vin[2] = 12'h900;
    wr(8'hB3, 8'h20);
    wr(8'hB1, 8'hD2);
    check(dac_code == 12'h800, "R6 first trial", dac_code, 12'h800);
    repeat (16) @(negedge clk);
    check(dac_code == 12'hC00, "R6 second trial kept", dac_code, 12'hC00);
    wr(8'hB1, 8'h12);
    rd(8'hB1, r); check(r[6:5] == 2'b00, "R12 abort clears start", r[6:5], 0);
    repeat (250) @(negedge clk);
    rd(8'hB1, r); check(r[5] == 1'b0, "R12 no flag after abort", r[5], 0);
    rd(8'hB2, r); check(r == hi0, "R12 rhi kept", r, hi0);
    rd(8'hB3, r); check(r[3:0] == lo0[3:0], "R12 rlo kept", r[3:0], lo0[3:0]);

    // R11 channel disabled: comparator sees nothing, result 0
    convert(3'd1, 1'b1, 1'b1, 1'b0, n);
    check(n == 12, "R9 latency gch off", n, 12);
    check(mux_en == 1'b0, "R11 mux off during gch=0", mux_en, 0);
    rd(8'hB2, r); check(r == 8'h00, "R11 result gch off", r, 0);

    // R7 resolution latched at start
    wr(8'hB3, 8'h40);
    wr(8'hB1, 8'hD7);
    wr(8'hB3, 8'h60);
    repeat (12) @(negedge clk);
    rd(8'hB1, r); check(r[5] == 1'b1, "R7 latched 8-bit done", r[5], 1);
    rd(8'hB2, r); check(r == 8'hA5, "R7 latched high", r, 8'hA5);
    rd(8'hB3, r); check(r[3:0] == 4'h0, "R7 latched low", r[3:0], 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule